// File: doc/BRIEF.md
# ADC SPI Command Sequencer

This block sits between user logic and a 24-bit delta-sigma converter on a four-wire serial link. User logic hands it one request at a time: fetch one conversion result, read one configuration register, write one configuration register, or send a one-byte control command. The sequencer drives chip select and a serial clock that idles low. It builds the command bytes and shifts them out. For a conversion fetch, it first waits for the converter's active-low data-ready line, and gives up after a programmable number of cycles. Between a read-type command and its response it inserts the turnaround delay the converter needs, then gathers the response bits into a result word.

A request is accepted with a valid/ready handshake. Completion is a one-cycle done pulse that carries the 24-bit result and a timeout flag. The serial clock rate, the system clock rate, the converter master clock rate and the turnaround length (in master clock periods) are parameters. The turnaround in system cycles is derived from them.

Top module: `adc_cmd_seq`

## Requirements
- R1: The serial link uses clock-idle-low, launch-on-rising, sample-on-falling: `spi_mosi` changes only on a cycle where `spi_sclk` rises, and `spi_miso` is captured on the falling edge.
- R2: A conversion fetch (`req_op` = 0) keeps chip select high until the synchronised `drdy_n` is low. It then sends byte 0x01 and clocks in three bytes. The result is first<<16 | second<<8 | third, with every byte most significant bit first.
- R3: A register read (`req_op` = 1) sends 0x10 | `req_addr`, then 0x00, then clocks in one byte. That byte is returned in `rsp_data[7:0]`, and bits 23:8 are zero.
- R4: A register write (`req_op` = 2) sends 0x50 | `req_addr`, then 0x00, then `req_data`, all within a single chip-select low period. `rsp_data` is zero.
- R5: A control command (`req_op` = 3) sends `req_data` as its only byte: wakeup 0x00, self-calibration 0xF0, sync 0xFC, standby 0xFD, reset 0xFE. `rsp_data` is zero.
- R6: For read types, the time from the last falling edge of the command to the first rising edge of the response is at least TURN_MCLK (default 60) periods of the converter master clock.
- R7: If `drdy_n` stays high for `timeout_lim` cycles during a conversion fetch, the request completes with `rsp_timeout` = 1 and `rsp_data` = 0, and chip select never falls.
- R8: Chip select falls at least one serial clock period before the first rising edge and rises at least one period after the last falling edge. `spi_sclk` is low whenever `spi_cs_n` is high.
- R9: `req_ready` is high exactly when no request is outstanding. Every accepted request yields exactly one `rsp_done` pulse, one cycle long.
- R10: Within a byte, rising edges of `spi_sclk` are spaced SYS_HZ/SCLK_HZ system cycles apart (1 µs by default).
- R11: During and straight after reset, `spi_cs_n` = 1, `spi_sclk` = 0, `rsp_done` = 0 and `req_ready` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request accepted when valid |
| req_op | input | 2 | 0 conversion fetch, 1 register read, 2 register write, 3 control command |
| req_addr | input | 4 | Register address for read/write |
| req_data | input | 8 | Write data, or command code for op 3 |
| timeout_lim | input | TO_W | Data-ready wait limit in system cycles |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_data | output | 24 | Result word, valid with rsp_done |
| rsp_timeout | output | 1 | Data-ready wait expired, valid with rsp_done |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to converter |
| spi_miso | input | 1 | Serial data from converter |
| drdy_n | input | 1 | Converter data ready, active low, asynchronous |

## Verification
A wrong sequencer state shows at the pins within one serial bit time. A skipped or repeated byte index changes the byte stream seen by the bench's slave model before chip select rises. A stuck or misloaded delay counter shows up as a turnaround, set-up or hold gap shorter than its bound, measured in nanoseconds at the very next clock edge. A handshake state that disagrees with the outstanding-request model shows as a `req_ready` mismatch on the first clock after the faulty transition. A missing or doubled done pulse is caught by the per-clock comparison in the same cycle.

// File: rtl/adc_seq_pkg.sv
// Shared types and byte codes for the converter command sequencer.
// Assumes request op codes are fixed as listed and visible to user logic.
package adc_seq_pkg;

    typedef enum logic [1:0] {
        OP_CONV = 2'd0,
        OP_RREG = 2'd1,
        OP_WREG = 2'd2,
        OP_CMD  = 2'd3
    } adc_op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WAIT,
        S_SETUP,
        S_TX,
        S_TURN,
        S_RX,
        S_HOLD
    } seq_state_e;

    localparam logic [7:0] BYTE_FETCH = 8'h01;
    localparam logic [7:0] BYTE_RREG  = 8'h10;
    localparam logic [7:0] BYTE_WREG  = 8'h50;
    localparam logic [7:0] BYTE_ONE   = 8'h00;

endpackage

// File: rtl/adc_dly_timer.sv
// Down-counting delay timer: load a value, then zero is flagged after that
// many cycles. Assumes a load is never required while the count is used.
module adc_dly_timer #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic         zero
);

    logic [W-1:0] cnt;

    // Count register: reload on request, otherwise decrement toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

    // R6: every timed wait (turnaround included) starts from the loaded value
    a_r6_timer_load: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt == $past(val)));

endmodule

// File: rtl/adc_byte_shift.sv
// Full-duplex byte shifter, clock idle low, launch on rising edge and sample
// on falling edge, most significant bit first. Assumes start is only raised
// while not busy; HALF is the serial half period in system cycles.
module adc_byte_shift #(
    parameter int HALF = 25
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       sclk,
    output logic       mosi,
    output logic       busy,
    output logic       done,
    output logic [7:0] rx_byte
);

    localparam int DW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [DW-1:0] DIV_END = DW'(HALF - 1);

    logic [DW-1:0] div;
    logic [2:0]    bits;
    logic [7:0]    sh;

    // Edge generator and shift registers for one byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div     <= '0;
            bits    <= '0;
            sh      <= '0;
            sclk    <= 1'b0;
            mosi    <= 1'b0;
            busy    <= 1'b0;
            done    <= 1'b0;
            rx_byte <= '0;
        end else begin
            done <= 1'b0;
            if (start && !busy) begin
                busy <= 1'b1;
                sh   <= tx_byte;
                div  <= '0;
                bits <= '0;
                sclk <= 1'b0;
            end else if (busy) begin
                if (div == DIV_END) begin
                    div <= '0;
                    if (!sclk) begin
                        sclk <= 1'b1;
                        mosi <= sh[7];
                        sh   <= {sh[6:0], 1'b0};
                    end else begin
                        sclk    <= 1'b0;
                        rx_byte <= {rx_byte[6:0], miso};
                        bits    <= bits + 1'b1;
                        if (bits == 3'd7) begin
                            busy <= 1'b0;
                            done <= 1'b1;
                        end
                    end
                end else begin
                    div <= div + 1'b1;
                end
            end
        end
    end

    // R1: data line moves only together with a rising clock edge
    a_r1_mosi_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mosi) |-> $rose(sclk));

endmodule

// File: rtl/adc_cmd_seq.sv
// Converter command sequencer: accepts one request, waits for data ready
// (fetch only, with timeout), frames chip select, shifts the command bytes,
// waits out the turnaround, gathers response bytes and pulses done.
// Assumes drdy_n is asynchronous (synchronised here) and that the parameters
// give HALF >= 1.
module adc_cmd_seq
    import adc_seq_pkg::*;
#(
    parameter int SYS_HZ    = 50_000_000,
    parameter int SCLK_HZ   = 1_000_000,
    parameter int MCLK_HZ   = 7_680_000,
    parameter int TURN_MCLK = 60,
    parameter int TO_W      = 24
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [1:0]      req_op,
    input  logic [3:0]      req_addr,
    input  logic [7:0]      req_data,
    input  logic [TO_W-1:0] timeout_lim,
    output logic            rsp_done,
    output logic [23:0]     rsp_data,
    output logic            rsp_timeout,
    output logic            spi_cs_n,
    output logic            spi_sclk,
    output logic            spi_mosi,
    input  logic            spi_miso,
    input  logic            drdy_n
);

    localparam int HALF     = SYS_HZ / (2 * SCLK_HZ);
    localparam int TURN_CYC = int'((64'(TURN_MCLK) * 64'(SYS_HZ) + 64'(MCLK_HZ) - 64'd1)
                                   / 64'(MCLK_HZ));
    localparam logic [TO_W-1:0] SETUP_V = TO_W'(HALF - 1);
    localparam logic [TO_W-1:0] HOLD_V  = TO_W'(2 * HALF - 1);
    localparam logic [TO_W-1:0] TURN_V  = TO_W'(TURN_CYC - 1);

    seq_state_e     st, st_nx;
    adc_op_e        op_q;
    logic [3:0]     addr_q;
    logic [7:0]     data_q;
    logic [1:0]     idx, ntx, nrx;
    logic [23:0]    acc;
    logic [1:0]     drdy_sync;
    logic           tmr_load, tmr_zero;
    logic [TO_W-1:0] tmr_val;
    logic           fin, fin_to, idx_inc, idx_clr, acc_push;
    logic           sh_start, sh_busy, sh_done;
    logic [7:0]     sh_tx, sh_rx;

    // Two-flop synchroniser for the asynchronous data-ready line.
    always_ff @(posedge clk) begin
        if (!rst_n) drdy_sync <= 2'b11;
        else        drdy_sync <= {drdy_sync[0], drdy_n};
    end

    // Byte counts per request type.
    always_comb begin
        case (op_q)
            OP_CONV: begin ntx = 2'd1; nrx = 2'd3; end
            OP_RREG: begin ntx = 2'd2; nrx = 2'd1; end
            OP_WREG: begin ntx = 2'd3; nrx = 2'd0; end
            default: begin ntx = 2'd1; nrx = 2'd0; end
        endcase
    end

    // Command byte selected by request type and byte index.
    always_comb begin
        sh_tx = 8'h00;
        if (st == S_TX) begin
            case (op_q)
                OP_CONV: sh_tx = BYTE_FETCH;
                OP_RREG: sh_tx = (idx == 2'd0) ? (BYTE_RREG | {4'h0, addr_q}) : BYTE_ONE;
                OP_WREG: sh_tx = (idx == 2'd0) ? (BYTE_WREG | {4'h0, addr_q}) :
                                 (idx == 2'd1) ? BYTE_ONE : data_q;
                default: sh_tx = data_q;
            endcase
        end
    end

    assign sh_start = ((st == S_TX) || (st == S_RX)) && !sh_busy && !sh_done;

    // Sequencer next state and timer loads.
    always_comb begin
        st_nx    = st;
        tmr_load = 1'b0;
        tmr_val  = '0;
        fin      = 1'b0;
        fin_to   = 1'b0;
        idx_inc  = 1'b0;
        idx_clr  = 1'b0;
        acc_push = 1'b0;
        case (st)
            S_IDLE: if (req_valid) begin
                tmr_load = 1'b1;
                if (req_op == OP_CONV) begin
                    st_nx   = S_WAIT;
                    tmr_val = timeout_lim;
                end else begin
                    st_nx   = S_SETUP;
                    tmr_val = SETUP_V;
                end
            end
            S_WAIT: if (!drdy_sync[1]) begin
                st_nx    = S_SETUP;
                tmr_load = 1'b1;
                tmr_val  = SETUP_V;
            end else if (tmr_zero) begin
                st_nx  = S_IDLE;
                fin    = 1'b1;
                fin_to = 1'b1;
            end
            S_SETUP: if (tmr_zero) begin
                st_nx   = S_TX;
                idx_clr = 1'b1;
            end
            S_TX: if (sh_done) begin
                if (idx == ntx - 2'd1) begin
                    idx_clr  = 1'b1;
                    tmr_load = 1'b1;
                    if (nrx != 2'd0) begin
                        st_nx   = S_TURN;
                        tmr_val = TURN_V;
                    end else begin
                        st_nx   = S_HOLD;
                        tmr_val = HOLD_V;
                    end
                end else begin
                    idx_inc = 1'b1;
                end
            end
            S_TURN: if (tmr_zero) st_nx = S_RX;
            S_RX: if (sh_done) begin
                acc_push = 1'b1;
                if (idx == nrx - 2'd1) begin
                    st_nx    = S_HOLD;
                    tmr_load = 1'b1;
                    tmr_val  = HOLD_V;
                end else begin
                    idx_inc = 1'b1;
                end
            end
            S_HOLD: if (tmr_zero) begin
                st_nx = S_IDLE;
                fin   = 1'b1;
            end
            default: st_nx = S_IDLE;
        endcase
    end

    // State, request capture, byte index, result assembly and response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st          <= S_IDLE;
            op_q        <= OP_CONV;
            addr_q      <= '0;
            data_q      <= '0;
            idx         <= '0;
            acc         <= '0;
            rsp_done    <= 1'b0;
            rsp_timeout <= 1'b0;
            rsp_data    <= '0;
        end else begin
            st       <= st_nx;
            rsp_done <= fin;
            if (st == S_IDLE && req_valid) begin
                op_q   <= adc_op_e'(req_op);
                addr_q <= req_addr;
                data_q <= req_data;
                acc    <= '0;
            end
            if (idx_clr)      idx <= '0;
            else if (idx_inc) idx <= idx + 2'd1;
            if (acc_push) acc <= {acc[15:0], sh_rx};
            if (fin) begin
                rsp_timeout <= fin_to;
                rsp_data    <= fin_to ? 24'h0 : acc;
            end
        end
    end

    assign req_ready = (st == S_IDLE);
    assign spi_cs_n  = (st == S_IDLE) || (st == S_WAIT);

    adc_dly_timer #(.W(TO_W)) tmr_i (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tmr_load),
        .val   (tmr_val),
        .zero  (tmr_zero)
    );

    adc_byte_shift #(.HALF(HALF)) shf_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (sh_start),
        .tx_byte (sh_tx),
        .miso    (spi_miso),
        .sclk    (spi_sclk),
        .mosi    (spi_mosi),
        .busy    (sh_busy),
        .done    (sh_done),
        .rx_byte (sh_rx)
    );

    // R8: serial clock parked low whenever chip select is released
    a_r8_sclk_low_idle: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sclk);
    // R9: done lasts exactly one cycle
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);
    // R9: an accepted request makes the sequencer busy
    a_r9_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
    // R7: a timed-out fetch never selected the converter
    a_r7_timeout_no_cs: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done && rsp_timeout) |-> spi_cs_n);

endmodule

// File: tb/adc_cmd_seq_tb_top.sv
`timescale 1ns/1ps
module adc_cmd_seq_tb_top;

    localparam real TCLK     = 20.0;
    localparam real SCLK_NS  = 1000.0;
    localparam real TURN_NS  = 60.0 * 1.0e9 / 7_680_000.0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_op = '0;
    logic [3:0]  req_addr = '0;
    logic [7:0]  req_data = '0;
    logic [23:0] timeout_lim = 24'd20000;
    logic        rsp_done;
    logic [23:0] rsp_data;
    logic        rsp_timeout;
    logic        spi_cs_n, spi_sclk, spi_mosi;
    logic        spi_miso = 1'b0;
    logic        drdy_n = 1'b1;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(TCLK/2) clk = ~clk;

    adc_cmd_seq dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
        .timeout_lim(timeout_lim), .rsp_done(rsp_done), .rsp_data(rsp_data),
        .rsp_timeout(rsp_timeout), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .drdy_n(drdy_n)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // ---------------- converter slave model ----------------
    logic [7:0] frame_q[$];
    logic [7:0] sr;
    int         bitn;
    int         frames = 0;
    int         resp_start = 1000;
    logic [23:0] resp_word = '0;
    realtime    t_cs_fall, t_last_rise, t_last_fall, t_drdy_fall;
    bit         first_rise;

    always @(negedge spi_cs_n) begin
        frame_q.delete();
        bitn = 0;
        first_rise = 1'b1;
        t_cs_fall = $realtime;
        frames++;
    end

    always @(posedge spi_sclk) begin
        if (first_rise) begin
            // R8: set-up from chip select to first edge
            chk(($realtime - t_cs_fall) >= SCLK_NS, "R8 setup", longint'($realtime - t_cs_fall), longint'(SCLK_NS));
            first_rise = 1'b0;
        end else if (bitn % 8 != 0) begin
            // R10: serial clock period within a byte
            chk(($realtime - t_last_rise) > SCLK_NS - 0.5 && ($realtime - t_last_rise) < SCLK_NS + 0.5,
                "R10 period", longint'($realtime - t_last_rise), longint'(SCLK_NS));
        end
        if (bitn == resp_start)
            // R6: turnaround before the first response edge
            chk(($realtime - t_last_fall) >= TURN_NS, "R6 turnaround", longint'($realtime - t_last_fall), longint'(TURN_NS));
        if (bitn >= resp_start && bitn < resp_start + 24)
            spi_miso = resp_word[23 - (bitn - resp_start)];
        else
            spi_miso = 1'b0;
        t_last_rise = $realtime;
    end

    always @(negedge spi_sclk) begin
        sr = {sr[6:0], spi_mosi};
        bitn++;
        if (bitn % 8 == 0 && bitn <= resp_start) frame_q.push_back(sr);
        t_last_fall = $realtime;
    end

    always @(posedge spi_cs_n) begin
        if (rst_n)
            // R8: hold after last edge
            chk(($realtime - t_last_fall) >= SCLK_NS, "R8 hold", longint'($realtime - t_last_fall), longint'(SCLK_NS));
    end

    // ---------------- per-clock reference model ----------------
    bit   busy_m = 1'b0, acc_seen = 1'b0, prev_done = 1'b0;
    logic prev_mosi = 1'b0, prev_sclk = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (acc_seen)  busy_m = 1'b1;
            if (rsp_done)  busy_m = 1'b0;
            chk(req_ready == !busy_m, "R9 ready model", req_ready, !busy_m);
            chk(!(rsp_done && prev_done), "R9 done width", rsp_done, 0);
            chk(!(spi_cs_n && spi_sclk), "R8 sclk idle", spi_sclk, 0);
            if (spi_mosi != prev_mosi)
                chk(spi_sclk && !prev_sclk, "R1 mosi launch", {prev_sclk, spi_sclk}, 2'b01);
            acc_seen = req_valid && req_ready;
        end
        prev_done = rsp_done;
        prev_mosi = spi_mosi;
        prev_sclk = spi_sclk;
    end

    // ---------------- request driver ----------------
    logic [23:0] r_data;
    logic        r_to;
    int          r_cyc;

    task automatic run_req(input logic [1:0] op, input logic [3:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        req_valid = 1'b1; req_op = op; req_addr = a; req_data = d;
        do @(negedge clk); while (!req_ready);
        @(posedge clk); #1;
        req_valid = 1'b0;
        r_cyc = 0;
        do begin @(negedge clk); r_cyc++; end while (!rsp_done);
        r_data = rsp_data;
        r_to   = rsp_timeout;
    endtask

    task automatic chk_frame(input string req, input logic [7:0] b0, input logic [7:0] b1,
                             input logic [7:0] b2, input int n);
        chk(frame_q.size() == n, req, frame_q.size(), n);
        if (frame_q.size() == n) begin
            if (n > 0) chk(frame_q[0] == b0, req, frame_q[0], b0);
            if (n > 1) chk(frame_q[1] == b1, req, frame_q[1], b1);
            if (n > 2) chk(frame_q[2] == b2, req, frame_q[2], b2);
        end
    endtask

    initial begin
        int f0;
        repeat (3) @(negedge clk);
        // R11: reset state
        chk(spi_cs_n == 1'b1, "R11 cs", spi_cs_n, 1);
        chk(spi_sclk == 1'b0, "R11 sclk", spi_sclk, 0);
        chk(rsp_done == 1'b0, "R11 done", rsp_done, 0);
        @(posedge clk); #1 rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R11 ready", req_ready, 1);

        // R5: control commands
        resp_start = 1000;
        run_req(2'd3, 4'h0, 8'hFC);
        chk_frame("R5 sync frame", 8'hFC, 0, 0, 1);
        chk(r_data == 24'h0 && !r_to, "R5 sync result", r_data, 0);
        run_req(2'd3, 4'h0, 8'hFE);
        chk_frame("R5 reset frame", 8'hFE, 0, 0, 1);
        run_req(2'd3, 4'h0, 8'h00);
        chk_frame("R5 wakeup frame", 8'h00, 0, 0, 1);

        // R4: register write in one chip-select frame
        f0 = frames;
        run_req(2'd2, 4'h3, 8'hA5);
        chk_frame("R4 write frame", 8'h53, 8'h00, 8'hA5, 3);
        chk(frames == f0 + 1, "R4 single frame", frames - f0, 1);
        chk(r_data == 24'h0, "R4 result", r_data, 0);

        // R3: register read
        resp_start = 16; resp_word = 24'h3C0000;
        run_req(2'd1, 4'hA, 8'h00);
        chk_frame("R3 read frame", 8'h1A, 8'h00, 0, 2);
        chk(r_data == 24'h00003C && !r_to, "R3 result", r_data, 24'h3C);

        // R2: conversion fetch waits for data ready
        resp_start = 8; resp_word = 24'h81C3E7;
        f0 = frames;
        fork
            run_req(2'd0, 4'h0, 8'h00);
            begin
                repeat (150) @(negedge clk);
                chk(frames == f0 && spi_cs_n, "R2 wait cs", frames - f0, 0);
                drdy_n = 1'b0; t_drdy_fall = $realtime;
            end
        join
        drdy_n = 1'b1;
        chk(t_cs_fall > t_drdy_fall, "R2 cs after drdy", longint'(t_cs_fall), longint'(t_drdy_fall));
        chk_frame("R2 fetch frame", 8'h01, 0, 0, 1);
        chk(r_data == 24'h81C3E7 && !r_to, "R2 result", r_data, 24'h81C3E7);

        // R2: second pattern, data ready already low
        resp_word = 24'h7F0001; drdy_n = 1'b0;
        run_req(2'd0, 4'h0, 8'h00);
        drdy_n = 1'b1;
        chk(r_data == 24'h7F0001, "R2 result 2", r_data, 24'h7F0001);

        // R7: timeout with data ready held high
        resp_start = 1000;
        timeout_lim = 24'd200;
        f0 = frames;
        run_req(2'd0, 4'h0, 8'h00);
        chk(r_to == 1'b1, "R7 flag", r_to, 1);
        chk(r_data == 24'h0, "R7 data", r_data, 0);
        chk(frames == f0, "R7 no cs", frames - f0, 0);
        chk(r_cyc >= 200 && r_cyc <= 210, "R7 latency", r_cyc, 200);

        repeat (5) @(negedge clk);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule